// File: doc/BRIEF.md
# Two-Bank SDRAM Command Front End

This block is the command-side front end of a two-bank synchronous DRAM model. On each rising clock edge it samples the chip select, the three active-low strobes (row, column, write) and the address bus. It turns them into one decoded command: activate, read, write, precharge, auto refresh, mode register set or no-operation. It also tracks which bank holds an open row and which row that is. It then hands a one-cycle command strobe, the bank index, the row or column address, an auto-precharge flag and a precharge target mask to the array logic behind it.

Address bit 10 is overloaded. On a read or write it asks for auto-precharge of the addressed bank. On a precharge it widens the command to both banks, and the bank-select bit is then disregarded. Accesses that do not fit the bank state are refused and reported on an error pulse. Examples are a read or write to a closed bank, or an activate to a bank that is already open.

Top module: `sdcmd_front`

## Requirements
- R1: After reset, cmd_vld_o=0, cmd_o=0, err_o=0, auto_pre_o=0, pre_mask_o=00 and open_o=00.
- R2: The strobe levels {ras_n,cas_n,we_n} sampled at a rising edge select the command. The result appears on the outputs after that edge as a one-cycle cmd_vld_o pulse. The codes on cmd_o are: 011→activate=1, 101→read=2, 110 is no-op, 100→write=3, 010→precharge=4, 001→refresh=5, 000→mode set=6. Both 111 and 110 give cmd_o=0 with cmd_vld_o low.
- R3: With cs_n_i high at the edge, no command is accepted and the bank state stays the same.
- R4: With cke_i low at the edge, nothing is decoded and the bank state stays the same.
- R5: Activate puts addr[11] on bank_o (0 is bank A, 1 is bank B) and addr[10:0] on row_o. It sets open_o[bank] and stores the row in open_row_o (bank A in bits 10:0, bank B in bits 21:11).
- R6: Read and write put addr[11] on bank_o and addr[COL_W-1:0] on col_o. COL_W is 10, 9 or 8 for a data width of 4, 8 or 16 (10 at the default).
- R7: On read or write, auto_pre_o equals addr[10]. When it is 1, the addressed bank is marked closed in the same update.
- R8: Precharge with addr[10]=1 gives pre_mask_o=11 and closes both banks, whatever addr[11] is.
- R9: Precharge with addr[10]=0 sets only pre_mask_o bit addr[11] and closes only that bank.
- R10: A read or write to a closed bank pulses err_o, keeps cmd_vld_o low and changes no bank state.
- R11: An activate to an open bank pulses err_o, keeps cmd_vld_o low and keeps the stored row.
- R12: Refresh and mode set pulse cmd_vld_o with their codes and leave open_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable, decoder frozen when low |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| addr_i | input | 12 | Address; bit 11 bank, bit 10 auto-precharge / all banks |
| cmd_vld_o | output | 1 | One-cycle strobe for an accepted command |
| cmd_o | output | 3 | Decoded command code |
| err_o | output | 1 | One-cycle pulse for a refused access |
| bank_o | output | 1 | Bank index of the command |
| row_o | output | 11 | Row address of an activate |
| col_o | output | COL_W | Column address of a read or write |
| auto_pre_o | output | 1 | Auto-precharge requested |
| pre_mask_o | output | 2 | Banks closed by a precharge |
| open_o | output | 2 | Per-bank open state |
| open_row_o | output | 22 | Open row of each bank |

## Verification
Every result belongs to the rising edge that sampled the command. Decoded fields, error pulse, open flags and stored rows all appear together right after that edge, with one register stage and no further delay. The bench changes the inputs at a falling edge and drops chip select at the next falling edge. It reads the outputs at that same falling edge, half a period after the sampling edge. One more falling edge later it confirms that the strobe has gone back to low.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int NUM_BANKS = 2;
  localparam int BANK_W    = 1;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } sd_cmd_e;

  function automatic sd_cmd_e strobes_to_cmd(input logic ras_n, input logic cas_n,
                                             input logic we_n);
    sd_cmd_e c;
    case ({ras_n, cas_n, we_n})
      3'b011:  c = CMD_ACT;
      3'b101:  c = CMD_RD;
      3'b100:  c = CMD_WR;
      3'b010:  c = CMD_PRE;
      3'b001:  c = CMD_REF;
      3'b000:  c = CMD_MRS;
      default: c = CMD_NOP;   // 111 idle, 110 burst stop: nothing to decode here
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int ROW_W    = 11,
  parameter int COL_W    = 10,
  parameter int AP_BIT   = 10,
  parameter int BANK_BIT = 11
) (
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output sd_cmd_e           cmd,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic              a10
);

  always_comb begin
    if (cke && !cs_n) cmd = strobes_to_cmd(ras_n, cas_n, we_n);
    else              cmd = CMD_NOP;
    bank = addr[BANK_BIT];
    row  = addr[ROW_W-1:0];
    col  = addr[COL_W-1:0];
    a10  = addr[AP_BIT];
  end

endmodule

// File: rtl/sdcmd_bank_track.sv
module sdcmd_bank_track
  import sdcmd_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  sd_cmd_e                    cmd,
  input  logic [BANK_W-1:0]          bank,
  input  logic [ROW_W-1:0]           row,
  input  logic                       a10,
  output logic                       accept,
  output logic                       refuse,
  output logic [NUM_BANKS-1:0]       open_q,
  output logic [NUM_BANKS*ROW_W-1:0] row_q
);

  logic hit_open;
  logic is_access;

  always_comb begin
    hit_open  = open_q[bank];
    is_access = (cmd == CMD_RD) || (cmd == CMD_WR);
    refuse    = ((cmd == CMD_ACT) && hit_open) || (is_access && !hit_open);
    accept    = (cmd != CMD_NOP) && !refuse;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic             sel;
    logic             open_d;
    logic             upd_en;
    logic [ROW_W-1:0] row_d;

    always_comb begin
      sel    = (bank == BANK_W'(g));
      open_d = open_q[g];
      row_d  = row_q[g*ROW_W +: ROW_W];
      upd_en = 1'b0;
      if (accept) begin
        if (cmd == CMD_ACT && sel) begin
          open_d = 1'b1;
          row_d  = row;
          upd_en = 1'b1;
        end else if (is_access && sel && a10) begin
          open_d = 1'b0;
          upd_en = 1'b1;
        end else if (cmd == CMD_PRE && (a10 || sel)) begin
          open_d = 1'b0;
          upd_en = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[g]                 <= 1'b0;
        row_q[g*ROW_W +: ROW_W]   <= '0;
      end else if (upd_en) begin
        open_q[g]                 <= open_d;
        row_q[g*ROW_W +: ROW_W]   <= row_d;
      end
    end
  end

endmodule

// File: rtl/sdcmd_front.sv
module sdcmd_front
  import sdcmd_pkg::*;
#(
  parameter int DATA_W   = 4,
  parameter int ADDR_W   = 12,
  parameter int ROW_W    = 11,
  parameter int AP_BIT   = 10,
  parameter int BANK_BIT = 11,
  localparam int COL_W   = (DATA_W == 16) ? 8 : (DATA_W == 8) ? 9 : 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke_i,
  input  logic                       cs_n_i,
  input  logic                       ras_n_i,
  input  logic                       cas_n_i,
  input  logic                       we_n_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic                       cmd_vld_o,
  output logic [2:0]                 cmd_o,
  output logic                       err_o,
  output logic [BANK_W-1:0]          bank_o,
  output logic [ROW_W-1:0]           row_o,
  output logic [COL_W-1:0]           col_o,
  output logic                       auto_pre_o,
  output logic [NUM_BANKS-1:0]       pre_mask_o,
  output logic [NUM_BANKS-1:0]       open_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sd_cmd_e             dec_cmd;
  logic [BANK_W-1:0]   dec_bank;
  logic [ROW_W-1:0]    dec_row;
  logic [COL_W-1:0]    dec_col;
  logic                dec_a10;
  logic                accept;
  logic                refuse;

  sdcmd_decode #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .AP_BIT(AP_BIT), .BANK_BIT(BANK_BIT)
  ) u_decode (
    .cke(cke_i), .cs_n(cs_n_i), .ras_n(ras_n_i), .cas_n(cas_n_i), .we_n(we_n_i),
    .addr(addr_i), .cmd(dec_cmd), .bank(dec_bank), .row(dec_row),
    .col(dec_col), .a10(dec_a10)
  );

  sdcmd_bank_track #(.ROW_W(ROW_W)) u_track (
    .clk(clk), .rst_n(rst_int_n), .cmd(dec_cmd), .bank(dec_bank), .row(dec_row),
    .a10(dec_a10), .accept(accept), .refuse(refuse),
    .open_q(open_o), .row_q(open_row_o)
  );

  // output stage: next-state logic
  sd_cmd_e              cmd_d,  cmd_q;
  logic                 vld_d,  vld_q;
  logic                 err_d,  err_q;
  logic [BANK_W-1:0]    bank_d, bank_q;
  logic [ROW_W-1:0]     row_d,  row_q;
  logic [COL_W-1:0]     col_d,  col_q;
  logic                 ap_d,   ap_q;
  logic [NUM_BANKS-1:0] mask_d, mask_q;

  always_comb begin
    cmd_d  = CMD_NOP;
    vld_d  = 1'b0;
    err_d  = refuse;
    bank_d = '0;
    row_d  = '0;
    col_d  = '0;
    ap_d   = 1'b0;
    mask_d = '0;
    if (accept) begin
      cmd_d = dec_cmd;
      vld_d = 1'b1;
      case (dec_cmd)
        CMD_ACT: begin
          bank_d = dec_bank;
          row_d  = dec_row;
        end
        CMD_RD, CMD_WR: begin
          bank_d = dec_bank;
          col_d  = dec_col;
          ap_d   = dec_a10;
        end
        CMD_PRE: begin
          bank_d = dec_bank;
          if (dec_a10) mask_d = '1;
          else         mask_d[dec_bank] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // output stage: registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_q  <= CMD_NOP;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
      bank_q <= bank_d;
      row_q  <= row_d;
      col_q  <= col_d;
      ap_q   <= ap_d;
      mask_q <= mask_d;
    end
  end

  assign cmd_o      = cmd_q;
  assign cmd_vld_o  = vld_q;
  assign err_o      = err_q;
  assign bank_o     = bank_q;
  assign row_o      = row_q;
  assign col_o      = col_q;
  assign auto_pre_o = ap_q;
  assign pre_mask_o = mask_q;

endmodule

// File: rtl/sdcmd_front_chk.sv
module sdcmd_front_chk #(
  parameter int ROW_W = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cke_i,
  input logic               cs_n_i,
  input logic               cmd_vld_o,
  input logic [2:0]         cmd_o,
  input logic               err_o,
  input logic               bank_o,
  input logic [ROW_W-1:0]   row_o,
  input logic [1:0]         pre_mask_o,
  input logic [1:0]         open_o,
  input logic [2*ROW_W-1:0] open_row_o
);

  logic [1:0] open_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_prev <= 2'b00;
    else        open_prev <= open_o;
  end

  a_r2_strobe_or_error: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_vld_o && err_o));

  a_r3_cs_high_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> (!cmd_vld_o && !err_o && $stable(open_o)));

  a_r4_cke_low_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_i |=> (!cmd_vld_o && !err_o && $stable(open_o)));

  a_r5_act_opens_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && cmd_o == 3'd1) |->
      (open_o[bank_o] &&
       ((bank_o ? open_row_o[2*ROW_W-1:ROW_W] : open_row_o[ROW_W-1:0]) == row_o)));

  a_r10_access_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && (cmd_o == 3'd2 || cmd_o == 3'd3)) |-> open_prev[bank_o]);

  a_r9_pre_mask_only_on_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_mask_o != 2'b00) |-> (cmd_vld_o && cmd_o == 3'd4));

  a_r8_pre_closes_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && cmd_o == 3'd4) |-> ((open_o & pre_mask_o) == 2'b00));

  a_r12_ref_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && (cmd_o == 3'd5 || cmd_o == 3'd6)) |-> (open_o == open_prev));

endmodule

bind sdcmd_front sdcmd_front_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .cs_n_i(cs_n_i),
  .cmd_vld_o(cmd_vld_o), .cmd_o(cmd_o), .err_o(err_o), .bank_o(bank_o),
  .row_o(row_o), .pre_mask_o(pre_mask_o), .open_o(open_o), .open_row_o(open_row_o)
);

// File: tb/sim_sdcmd_front.sv
module sim_sdcmd_front;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        cke_i;
  logic        cs_n_i;
  logic        ras_n_i;
  logic        cas_n_i;
  logic        we_n_i;
  logic [11:0] addr_i;
  logic        cmd_vld_o;
  logic [2:0]  cmd_o;
  logic        err_o;
  logic        bank_o;
  logic [10:0] row_o;
  logic [9:0]  col_o;
  logic        auto_pre_o;
  logic [1:0]  pre_mask_o;
  logic [1:0]  open_o;
  logic [21:0] open_row_o;

  int checks = 0;
  int fails  = 0;

  sdcmd_front u0 (
    .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i), .we_n_i(we_n_i), .addr_i(addr_i), .cmd_vld_o(cmd_vld_o),
    .cmd_o(cmd_o), .err_o(err_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .auto_pre_o(auto_pre_o), .pre_mask_o(pre_mask_o), .open_o(open_o),
    .open_row_o(open_row_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at a falling edge: drive pins, let one rising edge sample them,
  // return at the next falling edge with chip select released
  task automatic issue(input logic r, input logic c, input logic w, input logic [11:0] a);
    cs_n_i = 1'b0; ras_n_i = r; cas_n_i = c; we_n_i = w; addr_i = a;
    @(negedge clk);
    cs_n_i = 1'b1; ras_n_i = 1'b1; cas_n_i = 1'b1; we_n_i = 1'b1; addr_i = '0;
  endtask

  task automatic t_reset;
    chk("R1", "cmd_vld_o", cmd_vld_o, 0);
    chk("R1", "cmd_o", cmd_o, 0);
    chk("R1", "err_o", err_o, 0);
    chk("R1", "auto_pre_o", auto_pre_o, 0);
    chk("R1", "pre_mask_o", pre_mask_o, 0);
    chk("R1", "open_o", open_o, 0);
  endtask

  task automatic t_activate;
    issue(1'b0, 1'b1, 1'b1, 12'h155);
    chk("R2", "act vld", cmd_vld_o, 1);
    chk("R2", "act code", cmd_o, 1);
    chk("R5", "act bank", bank_o, 0);
    chk("R5", "act row", row_o, 11'h155);
    chk("R5", "open after A", open_o, 2'b01);
    chk("R5", "row A", open_row_o[10:0], 11'h155);
    @(negedge clk);
    chk("R2", "strobe one cycle", cmd_vld_o, 0);
    issue(1'b0, 1'b1, 1'b1, 12'hFFF);
    chk("R5", "act B bank", bank_o, 1);
    chk("R5", "open after B", open_o, 2'b11);
    chk("R5", "row B", open_row_o[21:11], 11'h7FF);
  endtask

  task automatic t_act_on_open;
    issue(1'b0, 1'b1, 1'b1, 12'h0AA);
    chk("R11", "err", err_o, 1);
    chk("R11", "vld", cmd_vld_o, 0);
    chk("R11", "row A kept", open_row_o[10:0], 11'h155);
    chk("R11", "open", open_o, 2'b11);
  endtask

  task automatic t_read;
    issue(1'b1, 1'b0, 1'b1, 12'hBFF);
    chk("R2", "rd code", cmd_o, 2);
    chk("R6", "rd bank", bank_o, 1);
    chk("R6", "rd col", col_o, 10'h3FF);
    chk("R7", "rd no ap", auto_pre_o, 0);
    chk("R7", "rd open kept", open_o, 2'b11);
  endtask

  task automatic t_write_ap;
    issue(1'b1, 1'b0, 1'b0, 12'h412);
    chk("R2", "wr code", cmd_o, 3);
    chk("R6", "wr bank", bank_o, 0);
    chk("R6", "wr col", col_o, 10'h012);
    chk("R7", "wr ap", auto_pre_o, 1);
    chk("R7", "A closed by ap", open_o, 2'b10);
  endtask

  task automatic t_closed_access;
    issue(1'b1, 1'b0, 1'b1, 12'h005);
    chk("R10", "rd err", err_o, 1);
    chk("R10", "rd vld", cmd_vld_o, 0);
    issue(1'b1, 1'b0, 1'b0, 12'h006);
    chk("R10", "wr err", err_o, 1);
    chk("R10", "wr vld", cmd_vld_o, 0);
    chk("R10", "open kept", open_o, 2'b10);
  endtask

  task automatic t_cs_high;
    cs_n_i = 1'b1; ras_n_i = 1'b0; cas_n_i = 1'b1; we_n_i = 1'b0; addr_i = 12'h400;
    @(negedge clk);
    ras_n_i = 1'b1; we_n_i = 1'b1; addr_i = '0;
    chk("R3", "vld", cmd_vld_o, 0);
    chk("R3", "open kept", open_o, 2'b10);
  endtask

  task automatic t_cke_low;
    cke_i = 1'b0;
    issue(1'b0, 1'b1, 1'b0, 12'h400);
    chk("R4", "vld", cmd_vld_o, 0);
    chk("R4", "open kept", open_o, 2'b10);
    cke_i = 1'b1;
  endtask

  task automatic t_pre_single;
    issue(1'b0, 1'b1, 1'b1, 12'h011);
    chk("R5", "reopen A", open_o, 2'b11);
    issue(1'b0, 1'b1, 1'b0, 12'h000);
    chk("R2", "pre code", cmd_o, 4);
    chk("R9", "mask A", pre_mask_o, 2'b01);
    chk("R9", "only A closed", open_o, 2'b10);
  endtask

  task automatic t_pre_all;
    issue(1'b0, 1'b1, 1'b1, 12'h022);
    issue(1'b0, 1'b1, 1'b0, 12'h400);
    chk("R8", "mask all", pre_mask_o, 2'b11);
    chk("R8", "all closed", open_o, 2'b00);
    issue(1'b0, 1'b1, 1'b1, 12'h833);
    issue(1'b0, 1'b1, 1'b0, 12'hC00);
    chk("R8", "mask all, bit11 high", pre_mask_o, 2'b11);
    chk("R8", "all closed again", open_o, 2'b00);
  endtask

  task automatic t_ref_mrs;
    issue(1'b0, 1'b1, 1'b1, 12'h844);
    issue(1'b0, 1'b0, 1'b1, 12'h000);
    chk("R12", "ref vld", cmd_vld_o, 1);
    chk("R12", "ref code", cmd_o, 5);
    chk("R12", "ref open", open_o, 2'b10);
    issue(1'b0, 1'b0, 1'b0, 12'h023);
    chk("R12", "mrs code", cmd_o, 6);
    chk("R12", "mrs open", open_o, 2'b10);
  endtask

  task automatic t_nop_codes;
    issue(1'b1, 1'b1, 1'b1, 12'h000);
    chk("R2", "111 vld", cmd_vld_o, 0);
    chk("R2", "111 code", cmd_o, 0);
    issue(1'b1, 1'b1, 1'b0, 12'h000);
    chk("R2", "110 vld", cmd_vld_o, 0);
    chk("R2", "110 err", err_o, 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke_i = 1'b1; cs_n_i = 1'b1; ras_n_i = 1'b1; cas_n_i = 1'b1;
    we_n_i = 1'b1; addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_activate;
    t_act_on_open;
    t_read;
    t_write_ap;
    t_closed_access;
    t_cs_high;
    t_cke_low;
    t_pre_single;
    t_pre_all;
    t_ref_mrs;
    t_nop_codes;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule